// File: doc/BRIEF.md
# Quantized-Voltage Gate Delay Element

This block stands in for one gate input when a circuit's timing is reproduced in clocked logic. Each clock period is one time quantum. An N-bit register holds a quantized voltage. While the logic input is high the register climbs along a rising transition curve. While the input is low it descends along a falling curve. The logic output is the top bit of the level. A long enough input pulse therefore passes through with the gate's typical delay. A shorter pulse comes out shortened, and a very short one is swallowed entirely.

The two curves are constant lookup tables, indexed by the present level, that hold the next level. They are computed at elaboration from the typical rise and fall delays, given in quanta as parameters. Each table samples an exponential charging curve whose 50% point falls at that delay. Because the step depends on where the level is, the count is non-linear. An input reversal in the middle of a swing starts the new ramp from the intermediate level, so the rise and fall do not restart from the rail.

Top module: `nlc_delay_elem`

## Requirements
- R1: On a clock edge with `rst_i` high, `lvl_o` becomes 0 when `RST_HIGH` is 0 and 2^N−1 when `RST_HIGH` is 1; `out_o` follows that level.
- R2: On each edge with reset low and `in_i` high, the level becomes min(M, v + max(1, round((M−v)·(1−2^(−1/RISE_Q))))), where v is the current level and M = 2^N−1.
- R3: On each edge with reset low and `in_i` low, the level becomes max(0, v − max(1, round(v·(1−2^(−1/FALL_Q))))).
- R4: The level saturates. It stays at M while the input is high and at 0 while the input is low.
- R5: `out_o` is 1 exactly when the level is at least 2^(N−1), which is the 50% threshold.
- R6: When the input reverses mid-swing, the next step departs from the current intermediate level. The ramp does not restart from either rail.
- R7: An input pulse that ends before the level crosses the threshold leaves `out_o` unchanged, so the pulse is filtered out.
- R8: After a partial swing, the next output edge comes sooner than it does after a full swing to the rail.
- R9: The rise and fall delays are set independently. With RISE_Q=2, FALL_Q=3 and N=5, a full-swing output rise takes 3 cycles and a full-swing output fall takes 4 cycles.
- R10: `out_o` can rise only after an edge that sampled `in_i` high, and can fall only after an edge that sampled `in_i` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one period is one time quantum |
| rst_i | input | 1 | Synchronous active-high reset |
| in_i | input | 1 | Logic level arriving at the gate input |
| lvl_o | output | LVL_W | Quantized voltage level |
| out_o | output | 1 | Logic output, the level's top bit |

## Verification
The bound checker watches several rules on every cycle. It checks that the level moves strictly toward the rail the input selects, that it holds once it reaches that rail, that reset loads the configured level, and that the output can only switch in the direction of the previously sampled input. The exact table values, filtering of short pulses, shortened delay after a partial swing, and the distinct rise and fall delays depend on entire input histories. Only the bench's sweep of pulse widths shows these, with every cycle compared against an arithmetic model of the curves.

// File: rtl/nlc_pkg.sv
package nlc_pkg;

  // Next quantized level along an exponential charge/discharge curve whose
  // 50% crossing lies dq quanta after leaving a rail.
  function automatic int curve_next(int lvl, int maxv, int dq, bit up);
    real k;
    real span;
    int  step;
    k    = 1.0 - 2.0 ** (-1.0 / real'(dq));
    span = up ? real'(maxv - lvl) : real'(lvl);
    step = $rtoi(span * k + 0.5);
    if (step < 1) step = 1;
    if (up) return (lvl + step > maxv) ? maxv : lvl + step;
    else    return (lvl - step < 0)    ? 0    : lvl - step;
  endfunction

endpackage

// File: rtl/nlc_curve_rom.sv
module nlc_curve_rom #(
  parameter int LVL_W  = 5,
  parameter int DQ     = 2,
  parameter bit RISING = 1'b1
) (
  input  logic [LVL_W-1:0] addr_i,
  output logic [LVL_W-1:0] rd_o
);
  localparam int DEPTH = 1 << LVL_W;
  localparam int MAXV  = DEPTH - 1;

  logic [LVL_W-1:0] tab [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    localparam logic [LVL_W-1:0] ENT = LVL_W'(nlc_pkg::curve_next(gi, MAXV, DQ, RISING));
    assign tab[gi] = ENT;
  end

  assign rd_o = tab[addr_i];
endmodule

// File: rtl/nlc_level_reg.sv
module nlc_level_reg #(
  parameter int LVL_W    = 5,
  parameter bit RST_HIGH = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [LVL_W-1:0] nxt_i,
  output logic [LVL_W-1:0] lvl_q
);
  localparam logic [LVL_W-1:0] RST_LVL = RST_HIGH ? {LVL_W{1'b1}} : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) lvl_q <= RST_LVL;
    else       lvl_q <= nxt_i;
  end
endmodule

// File: rtl/nlc_delay_elem.sv
module nlc_delay_elem #(
  parameter int LVL_W    = 5,
  parameter int RISE_Q   = 2,
  parameter int FALL_Q   = 3,
  parameter bit RST_HIGH = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             in_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             out_o
);
  logic [LVL_W-1:0] lvl_q;
  logic [LVL_W-1:0] up_nxt;
  logic [LVL_W-1:0] dn_nxt;
  logic [LVL_W-1:0] nxt;

  nlc_curve_rom #(.LVL_W(LVL_W), .DQ(RISE_Q), .RISING(1'b1)) u_rise_rom (
    .addr_i (lvl_q),
    .rd_o   (up_nxt)
  );

  nlc_curve_rom #(.LVL_W(LVL_W), .DQ(FALL_Q), .RISING(1'b0)) u_fall_rom (
    .addr_i (lvl_q),
    .rd_o   (dn_nxt)
  );

  // Input level selects the curve; tables clamp at the rails.
  assign nxt = in_i ? up_nxt : dn_nxt;

  nlc_level_reg #(.LVL_W(LVL_W), .RST_HIGH(RST_HIGH)) u_lvl (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .nxt_i (nxt),
    .lvl_q (lvl_q)
  );

  assign lvl_o = lvl_q;
  assign out_o = lvl_q[LVL_W-1];
endmodule

// File: rtl/nlc_delay_elem_chk.sv
module nlc_delay_elem_chk #(
  parameter int LVL_W    = 5,
  parameter bit RST_HIGH = 1'b0
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             in_i,
  input logic [LVL_W-1:0] lvl_o,
  input logic             out_o
);
  localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};
  localparam logic [LVL_W-1:0] RST_LVL = RST_HIGH ? TOP : '0;

  AST_RESET_LOAD: assert property (@(posedge clk_i)
    rst_i |=> lvl_o == RST_LVL); // R1

  AST_CLIMB: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_i && lvl_o != TOP) |=> lvl_o > $past(lvl_o)); // R2

  AST_DESCEND: assert property (@(posedge clk_i) disable iff (rst_i)
    (!in_i && lvl_o != '0) |=> lvl_o < $past(lvl_o)); // R3

  AST_HOLD_TOP: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_i && lvl_o == TOP) |=> lvl_o == TOP); // R4

  AST_HOLD_BOTTOM: assert property (@(posedge clk_i) disable iff (rst_i)
    (!in_i && lvl_o == '0) |=> lvl_o == '0); // R4

  AST_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(out_o) |-> $past(in_i)); // R10

  AST_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(out_o) |-> !$past(in_i)); // R10
endmodule

bind nlc_delay_elem nlc_delay_elem_chk #(.LVL_W(LVL_W), .RST_HIGH(RST_HIGH)) u_chk (.*);

// File: tb/nlc_delay_elem_bench.sv
module nlc_delay_elem_bench;
  localparam int W    = 5;
  localparam int MAXV = (1 << W) - 1;
  localparam int HALF = 1 << (W - 1);
  localparam int RQ   = 2;
  localparam int FQ   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic [W-1:0] lvl, lvl_hi;
  logic out, out_hi;

  int n_chk = 0;
  int n_fail = 0;
  int exp_lvl = 0;

  always #4 clk = ~clk;

  nlc_delay_elem #(.LVL_W(W), .RISE_Q(RQ), .FALL_Q(FQ), .RST_HIGH(1'b0)) u_nlc_delay_elem (
    .clk_i(clk), .rst_i(rst), .in_i(din), .lvl_o(lvl), .out_o(out));

  nlc_delay_elem #(.LVL_W(W), .RISE_Q(RQ), .FALL_Q(FQ), .RST_HIGH(1'b1)) u_hi (
    .clk_i(clk), .rst_i(rst), .in_i(din), .lvl_o(lvl_hi), .out_o(out_hi));

  function automatic int model(int v, bit up);
    real k;
    int  s;
    k = 1.0 - 2.0 ** (-1.0 / real'(up ? RQ : FQ));
    s = $rtoi((up ? real'(MAXV - v) : real'(v)) * k + 0.5);
    if (s < 1) s = 1;
    if (up) return (v + s > MAXV) ? MAXV : v + s;
    return (v - s < 0) ? 0 : v - s;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, compare.
  task automatic tick(bit v);
    din = v;
    @(posedge clk);
    exp_lvl = model(exp_lvl, v);
    @(negedge clk);
    check(int'(lvl) == exp_lvl, v ? "R2" : "R3", int'(lvl), exp_lvl);
    check(out == (exp_lvl >= HALF), "R5", int'(out), int'(exp_lvl >= HALF));
  endtask

  task automatic settle(bit v, int n);
    for (int i = 0; i < n; i++) tick(v);
  endtask

  initial begin
    int d_full, d_part, d_rise, m_rise, m_fall, m;
    repeat (3) @(negedge clk);
    check(int'(lvl) == 0, "R1", int'(lvl), 0);
    check(out == 1'b0, "R1", int'(out), 0);
    check(int'(lvl_hi) == MAXV, "R1", int'(lvl_hi), MAXV);
    check(out_hi == 1'b1, "R1", int'(out_hi), 1);
    rst = 1'b0;
    din = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(int'(lvl_hi) == model(MAXV, 1'b0), "R3", int'(lvl_hi), model(MAXV, 1'b0));
    exp_lvl = 0;

    // Sweep high/low pulse widths, every cycle compared with the model.
    for (int hi = 1; hi <= 10; hi++)
      for (int lo = 1; lo <= 10; lo++) begin
        settle(1'b1, hi);
        settle(1'b0, lo);
      end

    // R4 saturation at both rails
    settle(1'b1, 20);
    check(int'(lvl) == MAXV, "R4", int'(lvl), MAXV);
    tick(1'b1);
    check(int'(lvl) == MAXV, "R4", int'(lvl), MAXV);
    settle(1'b0, 25);
    check(int'(lvl) == 0, "R4", int'(lvl), 0);
    tick(1'b0);
    check(int'(lvl) == 0, "R4", int'(lvl), 0);

    // R6 reversal from intermediate level
    settle(1'b1, 2);
    m = int'(lvl);
    tick(1'b0);
    check(int'(lvl) == model(m, 1'b0), "R6", int'(lvl), model(m, 1'b0));
    check(int'(lvl) != model(MAXV, 1'b0), "R6", int'(lvl), model(m, 1'b0));
    settle(1'b0, 20);

    // R7 one-quantum pulse is filtered
    tick(1'b1);
    check(out == 1'b0, "R7", int'(out), 0);
    for (int i = 0; i < 8; i++) begin
      tick(1'b0);
      check(out == 1'b0, "R7", int'(out), 0);
    end

    // R9 full-swing rise and fall delays
    m_rise = 0; m = 0;
    while (m < HALF) begin m = model(m, 1'b1); m_rise++; end
    m_fall = 0; m = MAXV;
    while (m >= HALF) begin m = model(m, 1'b0); m_fall++; end
    d_rise = 0;
    while (out == 1'b0 && d_rise < 40) begin tick(1'b1); d_rise++; end
    check(d_rise == 3 && d_rise == m_rise, "R9", d_rise, 3);
    settle(1'b1, 20);
    d_full = 0;
    while (out == 1'b1 && d_full < 40) begin tick(1'b0); d_full++; end
    check(d_full == 4 && d_full == m_fall, "R9", d_full, 4);
    settle(1'b0, 20);

    // R8 partial swing gives a shorter delay
    d_rise = 0;
    while (out == 1'b0 && d_rise < 40) begin tick(1'b1); d_rise++; end
    d_part = 0;
    while (out == 1'b1 && d_part < 40) begin tick(1'b0); d_part++; end
    check(d_part < d_full, "R8", d_part, d_full - 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule